// File: doc/BRIEF.md
# NAND Bus Cycle Timing Sequencer

This block turns one request from a valid/ready interface into the strobe waveform of a single access on an asynchronous NAND flash bus. A request is a command byte, an address byte, a data read or a data write. Every access runs through a setup phase, a strobe (wait) phase and a hold phase. Each phase lasts a number of controller clock cycles taken from a programmable timing word. Data accesses draw their counts from one timing word, and command and address accesses draw theirs from a second, independent word.

A read that comes straight after a command or an address gets an extra programmable delay before its read strobe. Write accesses keep the data drivers off for a programmable high-impedance interval before they drive the bus. While the wait phase lasts, the device busy line can stretch it. Data accesses move 8 or 16 bits. A request may force 8 bits for its own transfer alone.

A small write port loads the timing words, the two read delays and the control bits. The block holds no data of its own beyond the single access in flight.

Top module: `nand_cycle_seq`

## Requirements
- R1: Reset values: chip enable is high (inactive), CLE and ALE are low, the RE and WE strobes are high, the output enable is low and req_ready is high. Both timing words reset to 0x0A0A0A0A, so a first data read lasts 30 cycles. Each read delay resets to 15, and wait-enable and wide both reset to 0.
- R2: Chip enable is low from the cycle after acceptance to the end of hold. CLE is high for the whole of a command access and ALE for the whole of an address access. The setup, strobe and hold phases last exactly their programmed counts.
- R3: A timing word holds setup in bits 7:0, strobe count in bits 15:8, hold in bits 23:16 and high-Z in bits 31:24. Data reads and writes take the data word. Command and address accesses take the command/address word.
- R4: A setup, strobe or hold field of 0 runs as 1 cycle.
- R5: During the strobe phase, WE is low for command, address and data-write accesses, and RE is low for data reads. The two strobes are never low at the same time.
- R6: A data read that directly follows a command inserts (CLE-delay + 1) cycles before its setup phase, with chip enable low. A data read that directly follows an address inserts (ALE-delay + 1) cycles instead. Any other read inserts none.
- R7: On a write-type access, the output enable rises when the cycle index counted from the first setup cycle reaches high-Z + 1, and it stays high through hold. It is never high on a read. nand_dout is stable while the output enable is high.
- R8: When wait-enable is 1, the strobe phase extends for as long as nand_rb is 0 (busy) at the end of its last counted cycle. When wait-enable is 0, nand_rb has no effect.
- R9: A data access is 16 bits wide when the wide control is 1 and req_narrow is 0. Otherwise it is 8 bits wide, and bits 15:8 of nand_dout and rdata are 0. Command and address accesses are always 8 bits wide.
- R10: req_type encodes 0 = command, 1 = address, 2 = data read, 3 = data write. A request is accepted on a clock edge where req_valid and req_ready are both high, and req_ready is high only while no access is in progress. done is high for exactly the last hold cycle. At done, rdata holds nand_din as sampled in the last strobe cycle of a read.
- R11: cfg_addr selects what cfg_wr loads: 0 loads the data timing word, 1 loads the command/address word, 2 loads the delays (CLE-delay in bits 3:0, ALE-delay in bits 7:4), and 3 loads the controls (wait-enable in bit 0, wide in bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_type | input | 2 | Access type |
| req_narrow | input | 1 | Force an 8-bit data transfer |
| req_wdata | input | DATA_W | Command, address or write data |
| done | output | 1 | Access finishing this cycle |
| rdata | output | DATA_W | Read data |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_dout | output | DATA_W | Data driven to the bus |
| nand_dout_en | output | 1 | Data driver enable |
| nand_din | input | DATA_W | Data from the bus |
| nand_rb | input | 1 | Device ready (1) / busy (0) |

## Verification
The bench goes after the read delay that follows a command or an address. A design that forgot which access came last would either drop the delay or apply the wrong one, and the cycle count to done would be off. Zero-valued fields are exercised because a design that loaded them raw would wrap its counter and run 256 cycles. The busy extension is driven both with wait-enable set and with it cleared, which catches a stretch that is missing as well as one that is unconditional. The high-Z interval and the 8-bit masking are compared cycle by cycle, which exposes an enable that is off by one cycle and upper data bits that leak through.

// File: rtl/nand_seq_pkg.sv
`timescale 1ns/1ps
package nand_seq_pkg;
  localparam int FLD_W = 8;
  localparam int DLY_W = 4;
  localparam logic [31:0] TIM_RST = 32'h0A0A_0A0A;
  localparam logic [DLY_W-1:0] DLY_RST = '1;

  typedef enum logic [1:0] {
    ACC_CMD  = 2'd0,
    ACC_ADDR = 2'd1,
    ACC_RD   = 2'd2,
    ACC_WR   = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PRE   = 3'd1,
    PH_SETUP = 3'd2,
    PH_WAIT  = 3'd3,
    PH_HOLD  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    LAST_NONE = 2'd0,
    LAST_CMD  = 2'd1,
    LAST_ADDR = 2'd2
  } last_e;

  typedef struct packed {
    logic [FLD_W-1:0] hiz;
    logic [FLD_W-1:0] hold;
    logic [FLD_W-1:0] wt;
    logic [FLD_W-1:0] setup;
  } tim_t;

  // counter load value for a phase: a zero field behaves as one cycle
  function automatic logic [FLD_W-1:0] phase_load(input logic [FLD_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction
endpackage

// File: rtl/nand_seq_cfg.sv
`timescale 1ns/1ps
module nand_seq_cfg
  import nand_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output tim_t             data_tim,
  output tim_t             ca_tim,
  output logic [DLY_W-1:0] cle_dly,
  output logic [DLY_W-1:0] ale_dly,
  output logic             wait_en,
  output logic             wide
);
  tim_t             data_q, data_d, ca_q, ca_d;
  logic [DLY_W-1:0] cle_q, cle_d, ale_q, ale_d;
  logic [1:0]       ctl_q, ctl_d;

  always_comb begin
    data_d = data_q;
    ca_d   = ca_q;
    cle_d  = cle_q;
    ale_d  = ale_q;
    ctl_d  = ctl_q;
    case (cfg_addr)
      2'd0: data_d = tim_t'(cfg_wdata);
      2'd1: ca_d   = tim_t'(cfg_wdata);
      2'd2: begin
        cle_d = cfg_wdata[DLY_W-1:0];
        ale_d = cfg_wdata[2*DLY_W-1:DLY_W];
      end
      default: ctl_d = cfg_wdata[1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= tim_t'(TIM_RST);
      ca_q   <= tim_t'(TIM_RST);
      cle_q  <= DLY_RST;
      ale_q  <= DLY_RST;
      ctl_q  <= 2'b00;
    end else if (cfg_wr) begin
      data_q <= data_d;
      ca_q   <= ca_d;
      cle_q  <= cle_d;
      ale_q  <= ale_d;
      ctl_q  <= ctl_d;
    end
  end

  assign data_tim = data_q;
  assign ca_tim   = ca_q;
  assign cle_dly  = cle_q;
  assign ale_dly  = ale_q;
  assign wait_en  = ctl_q[0];
  assign wide     = ctl_q[1];
endmodule

// File: rtl/nand_seq_fsm.sv
`timescale 1ns/1ps
module nand_seq_fsm
  import nand_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  acc_e             req_type,
  input  tim_t             data_tim,
  input  tim_t             ca_tim,
  input  logic [DLY_W-1:0] cle_dly,
  input  logic [DLY_W-1:0] ale_dly,
  input  logic             wait_en,
  input  logic             rb_ready,
  output logic             accept,
  output phase_e           phase,
  output acc_e             acc,
  output logic             wait_last,
  output logic             done
);
  phase_e           phase_q, phase_d;
  acc_e             acc_q, acc_d;
  last_e            last_q, last_d;
  logic [FLD_W-1:0] cnt_q, cnt_d;
  tim_t             in_tim, cur_tim;
  logic             stall, cnt_zero;

  assign in_tim   = req_type[1] ? data_tim : ca_tim;
  assign cur_tim  = acc_q[1] ? data_tim : ca_tim;
  assign stall    = wait_en && !rb_ready;
  assign cnt_zero = (cnt_q == '0);
  assign accept   = (phase_q == PH_IDLE) && req_valid;

  always_comb begin
    phase_d = phase_q;
    acc_d   = acc_q;
    last_d  = last_q;
    cnt_d   = cnt_zero ? cnt_q : cnt_q - 1'b1;
    case (phase_q)
      PH_IDLE: begin
        cnt_d = cnt_q;
        if (req_valid) begin
          acc_d = req_type;
          if (req_type == ACC_RD && last_q != LAST_NONE) begin
            phase_d = PH_PRE;
            cnt_d   = {{(FLD_W-DLY_W){1'b0}}, (last_q == LAST_CMD) ? cle_dly : ale_dly};
          end else begin
            phase_d = PH_SETUP;
            cnt_d   = phase_load(in_tim.setup);
          end
        end
      end
      PH_PRE: if (cnt_zero) begin
        phase_d = PH_SETUP;
        cnt_d   = phase_load(cur_tim.setup);
      end
      PH_SETUP: if (cnt_zero) begin
        phase_d = PH_WAIT;
        cnt_d   = phase_load(cur_tim.wt);
      end
      PH_WAIT: if (cnt_zero && !stall) begin
        phase_d = PH_HOLD;
        cnt_d   = phase_load(cur_tim.hold);
      end
      PH_HOLD: if (cnt_zero) begin
        phase_d = PH_IDLE;
        case (acc_q)
          ACC_CMD:  last_d = LAST_CMD;
          ACC_ADDR: last_d = LAST_ADDR;
          default:  last_d = LAST_NONE;
        endcase
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      acc_q   <= ACC_CMD;
      last_q  <= LAST_NONE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      acc_q   <= acc_d;
      last_q  <= last_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase     = phase_q;
  assign acc       = acc_q;
  assign wait_last = (phase_q == PH_WAIT) && cnt_zero && !stall;
  assign done      = (phase_q == PH_HOLD) && cnt_zero;
endmodule

// File: rtl/nand_seq_pins.sv
`timescale 1ns/1ps
module nand_seq_pins
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  acc_e              req_type,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_narrow,
  input  logic              wide,
  input  logic [FLD_W-1:0]  hiz_in,
  input  phase_e            phase,
  input  acc_e              acc,
  input  logic              wait_last,
  input  logic [DATA_W-1:0] nand_din,
  output logic              ce_n,
  output logic              cle,
  output logic              ale,
  output logic              re_n,
  output logic              we_n,
  output logic              oe,
  output logic [DATA_W-1:0] nand_dout,
  output logic [DATA_W-1:0] rdata
);
  localparam int NARROW_W = DATA_W / 2;
  localparam int HZ_W     = FLD_W + 1;

  logic              wide_in, wide_q, active, is_rd;
  logic [DATA_W-1:0] wdata_q, wdata_d, rdata_q, rdata_d;
  logic [HZ_W-1:0]   hz_q, hz_d;

  assign wide_in = wide && !req_narrow && req_type[1];
  assign active  = (phase == PH_SETUP) || (phase == PH_WAIT) || (phase == PH_HOLD);
  assign is_rd   = (acc == ACC_RD);

  always_comb begin
    wdata_d = wide_in ? req_wdata
                      : {{(DATA_W-NARROW_W){1'b0}}, req_wdata[NARROW_W-1:0]};
    rdata_d = wide_q ? nand_din
                     : {{(DATA_W-NARROW_W){1'b0}}, nand_din[NARROW_W-1:0]};
    hz_d    = (hz_q == '0) ? hz_q : hz_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      wide_q  <= 1'b0;
      hz_q    <= '0;
    end else if (accept) begin
      wdata_q <= wdata_d;
      wide_q  <= wide_in;
      hz_q    <= {1'b0, hiz_in} + 1'b1;
    end else if (active) begin
      hz_q    <= hz_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rdata_q <= '0;
    else if (wait_last && is_rd) rdata_q <= rdata_d;
  end

  assign ce_n      = (phase == PH_IDLE);
  assign cle       = !ce_n && (acc == ACC_CMD);
  assign ale       = !ce_n && (acc == ACC_ADDR);
  assign re_n      = !((phase == PH_WAIT) && is_rd);
  assign we_n      = !((phase == PH_WAIT) && !is_rd);
  assign oe        = active && !is_rd && (hz_q == '0);
  assign nand_dout = wdata_q;
  assign rdata     = rdata_q;
endmodule

// File: rtl/nand_cycle_seq.sv
`timescale 1ns/1ps
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_type,
  input  logic              req_narrow,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_re_n,
  output logic              nand_we_n,
  output logic [DATA_W-1:0] nand_dout,
  output logic              nand_dout_en,
  input  logic [DATA_W-1:0] nand_din,
  input  logic              nand_rb
);
  tim_t             data_tim, ca_tim;
  logic [DLY_W-1:0] cle_dly, ale_dly;
  logic             wait_en, wide, accept, wait_last;
  phase_e           phase;
  acc_e             acc, type_e;
  logic [FLD_W-1:0] hiz_sel;

  assign type_e    = acc_e'(req_type);
  assign hiz_sel   = req_type[1] ? data_tim.hiz : ca_tim.hiz;
  assign req_ready = (phase == PH_IDLE);

  nand_seq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .data_tim(data_tim), .ca_tim(ca_tim),
    .cle_dly(cle_dly), .ale_dly(ale_dly), .wait_en(wait_en), .wide(wide)
  );

  nand_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(type_e),
    .data_tim(data_tim), .ca_tim(ca_tim), .cle_dly(cle_dly), .ale_dly(ale_dly),
    .wait_en(wait_en), .rb_ready(nand_rb), .accept(accept), .phase(phase),
    .acc(acc), .wait_last(wait_last), .done(done)
  );

  nand_seq_pins #(.DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_type(type_e),
    .req_wdata(req_wdata), .req_narrow(req_narrow), .wide(wide),
    .hiz_in(hiz_sel), .phase(phase), .acc(acc), .wait_last(wait_last),
    .nand_din(nand_din), .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale),
    .re_n(nand_re_n), .we_n(nand_we_n), .oe(nand_dout_en),
    .nand_dout(nand_dout), .rdata(rdata)
  );
endmodule

// File: rtl/nand_cycle_seq_chk.sv
`timescale 1ns/1ps
module nand_cycle_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic              nand_ce_n,
  input logic              nand_cle,
  input logic              nand_ale,
  input logic              nand_re_n,
  input logic              nand_we_n,
  input logic [DATA_W-1:0] nand_dout,
  input logic              nand_dout_en
);
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_re_n && !nand_we_n));

  p_strobe_needs_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_re_n || !nand_we_n) |-> !nand_ce_n);

  p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dout_en);

  p_dout_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_dout_en && $past(nand_dout_en)) |-> $stable(nand_dout));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_in_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!nand_ce_n && nand_re_n && nand_we_n && !req_ready));

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nand_ce_n && !nand_dout_en));
endmodule

bind nand_cycle_seq nand_cycle_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_nand_cycle_seq.sv
`timescale 1ns/1ps
module tb_nand_cycle_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_type = 2'd0;
  logic        req_narrow = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        done;
  logic [15:0] rdata;
  logic        nand_ce_n, nand_cle, nand_ale, nand_re_n, nand_we_n, nand_dout_en;
  logic [15:0] nand_dout;
  logic [15:0] nand_din = '0;
  logic        nand_rb = 1'b1;

  nand_cycle_seq #(.DATA_W(16)) dut (.*);

  always #4 clk = ~clk;

  typedef struct packed {
    logic ce_n, cle, ale, re_n, we_n, oe, done, rd;
    logic [15:0] d;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_err = 0;
  bit mon_on = 0;
  logic [31:0] m_dt = 32'h0A0A0A0A, m_ct = 32'h0A0A0A0A;
  int m_cle = 15, m_ale = 15, m_prev = -1;
  bit m_wen = 0, m_wide = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic int at_least1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // behavioural model: expands one access into its expected per-cycle waveform
  task automatic build(input int t, input logic [15:0] d, input bit nar, input int bk, output int tot);
    logic [31:0] tw;
    int s, w, h, z, p;
    bit wd;
    logic [15:0] ed;
    exp_t e;
    tw = (t >= 2) ? m_dt : m_ct;
    s = at_least1(tw[7:0]); w = at_least1(tw[15:8]);
    h = at_least1(tw[23:16]); z = tw[31:24];
    p = 0;
    if (t == 2 && m_prev == 0) p = m_cle + 1;
    if (t == 2 && m_prev == 1) p = m_ale + 1;
    if (m_wen && bk > 0 && (bk - (p + s) + 1) > w) w = bk - (p + s) + 1;
    wd = m_wide && !nar && (t >= 2);
    ed = wd ? d : {8'h00, d[7:0]};
    tot = p + s + w + h;
    for (int i = 0; i < tot; i++) begin
      e.ce_n = 1'b0;
      e.cle  = (t == 0);
      e.ale  = (t == 1);
      e.re_n = !((i >= p + s) && (i < p + s + w) && t == 2);
      e.we_n = !((i >= p + s) && (i < p + s + w) && t != 2);
      e.oe   = (t != 2) && (i >= p) && ((i - p) >= z + 1);
      e.done = (i == tot - 1);
      e.rd   = (t == 2);
      e.d    = ed;
      q.push_back(e);
    end
    m_prev = (t < 2) ? t : -1;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      exp_t e;
      bit idle;
      idle = (q.size() == 0);
      if (idle) e = '{ce_n:1'b1, cle:1'b0, ale:1'b0, re_n:1'b1, we_n:1'b1, oe:1'b0, done:1'b0, rd:1'b0, d:16'h0};
      else e = q.pop_front();
      chk(nand_ce_n == e.ce_n, "R2", "ce_n", nand_ce_n, e.ce_n);
      chk(nand_cle == e.cle, "R2", "cle", nand_cle, e.cle);
      chk(nand_ale == e.ale, "R2", "ale", nand_ale, e.ale);
      chk(nand_re_n == e.re_n, "R5", "re_n", nand_re_n, e.re_n);
      chk(nand_we_n == e.we_n, "R5", "we_n", nand_we_n, e.we_n);
      chk(nand_dout_en == e.oe, "R7", "dout_en", nand_dout_en, e.oe);
      chk(done == e.done, "R10", "done", done, e.done);
      chk(req_ready == idle, "R10", "req_ready", req_ready, idle);
      if (e.oe) chk(nand_dout == e.d, "R9", "dout", nand_dout, e.d);
      if (e.done && e.rd) chk(rdata == e.d, "R9", "rdata", rdata, e.d);
    end
  end

  task automatic wcfg(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk); #1;
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    case (a)
      2'd0: m_dt = v;
      2'd1: m_ct = v;
      2'd2: begin m_cle = v[3:0]; m_ale = v[7:4]; end
      default: begin m_wen = v[0]; m_wide = v[1]; end
    endcase
  endtask

  // t: 0 cmd, 1 addr, 2 read, 3 write; bk: cycle index from which nand_rb is ready
  task automatic run(input int t, input logic [15:0] d, input bit nar, input int bk, input string tag);
    int tot, n;
    bit seen;
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R10", "ready before issue", req_ready, 1);
    if (bk > 0) nand_rb = 1'b0;
    if (t == 2) nand_din = d;
    req_valid = 1'b1; req_type = t[1:0]; req_wdata = d; req_narrow = nar;
    build(t, d, nar, bk, tot);
    @(posedge clk);
    n = 0; seen = 0;
    while (!seen && n < 5000) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (n == bk) nand_rb = 1'b1;
      seen = done;
      n++;
    end
    chk(n == tot, tag, "cycles to done", n, tot);
    nand_rb = 1'b1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(nand_ce_n == 1'b1, "R1", "ce_n after reset", nand_ce_n, 1);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(nand_dout_en == 1'b0, "R1", "dout_en after reset", nand_dout_en, 0);
    chk(nand_re_n && nand_we_n, "R1", "strobes after reset", {nand_re_n, nand_we_n}, 3);
    mon_on = 1;
    // R1: reset timing words give 10/10/10, 8-bit width
    run(2, 16'hA55A, 0, 0, "R1");
    // R6: reset delays of 15 give 16 cycles before the read
    run(0, 16'h0070, 0, 0, "R2");
    run(2, 16'h1234, 0, 0, "R6");
    run(1, 16'h0011, 0, 0, "R2");
    run(2, 16'h4321, 0, 0, "R6");
    run(3, 16'hBEEF, 0, 0, "R7");
    run(2, 16'h00C3, 0, 0, "R6");
    // R11: delay register layout
    wcfg(2'd2, 32'h0000_0052);
    run(0, 16'h0090, 0, 0, "R2");
    run(2, 16'h0F0F, 0, 0, "R6");
    run(0, 16'h0005, 0, 0, "R2");
    run(1, 16'h0022, 0, 0, "R2");
    run(2, 16'h3C3C, 0, 0, "R11");
    // R3: independent timing words, field layout
    wcfg(2'd0, 32'h0203_0405);
    wcfg(2'd1, 32'h0102_0103);
    run(3, 16'h1357, 0, 0, "R3");
    run(0, 16'hABCD, 0, 0, "R3");
    run(1, 16'h00E1, 0, 0, "R3");
    run(2, 16'h2468, 0, 0, "R3");
    // R4: zero fields run as one cycle
    wcfg(2'd0, 32'h0000_0000);
    run(3, 16'h0077, 0, 0, "R4");
    run(2, 16'h0088, 0, 0, "R4");
    wcfg(2'd1, 32'h0000_0000);
    run(0, 16'h0066, 0, 0, "R4");
    // R8: busy stretch with wait enable, ignored without it
    wcfg(2'd0, 32'h0102_0302);
    wcfg(2'd3, 32'h0000_0001);
    run(2, 16'h0099, 0, 20, "R8");
    run(3, 16'h00AA, 0, 15, "R8");
    run(3, 16'h00AB, 0, 2, "R8");
    wcfg(2'd3, 32'h0000_0000);
    run(2, 16'h00BB, 0, 20, "R8");
    // R9: wide bus, per-transfer narrowing, command stays 8-bit
    wcfg(2'd3, 32'h0000_0002);
    run(3, 16'hCAFE, 0, 0, "R9");
    run(3, 16'hCAFE, 1, 0, "R9");
    run(2, 16'hF00D, 0, 0, "R9");
    run(2, 16'hF00D, 1, 0, "R9");
    run(0, 16'hABCD, 0, 0, "R9");
    run(2, 16'h5AA5, 0, 0, "R6");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule